// File: doc/BRIEF.md
# Masking Cycle Shifter

This block is a 16-bit field shifter placed in front of the A input of an ALU. Each cycle it takes a register-file word, a T word and a memory-data word. Two of these sources, the register word and the T word, are placed in a high and a low half to form a 32-bit value. Either source may go in either half, and the same source may fill both halves. The 32-bit value is cycled left by a 4-bit count, and the upper 16 bits of the result are kept.

A left mask and a right mask are then built from two width inputs. A mode input selects which of the two masks are active. Each masked position is either forced to zero or taken from the memory-data word. The result is registered, and it is delivered in complemented form. The next stage must invert it to recover the true value.

The usual shifter operations are all settings of the same inputs. Some examples:
- A two-word cycle uses no mask.
- A logical right shift by n puts one operand in both halves, cycles left by (16-n) mod 16 and applies an n-bit left mask.
- A right cycle by n is a left cycle by 16-n with the two halves swapped.
- A field load of size s at position p uses a left mask of width 16-s and a cycle of (16-p) mod 16.

Top module: `mask_cycle_shifter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_n` becomes all ones, which stands for a true result of zero.
- R2: When `mask_mode` is 2'b00 (no mask), `res_n` is the complement of bits 31..16 of the 32-bit word {high half, low half} after it is cycled left by `cyc_cnt` places.
- R3: When `cyc_cnt` is 0 and there is no mask, the true result equals the high-half operand unchanged.
- R4: When `hi_src` or `lo_src` is 0, that half takes `rf_word`. When it is 1, that half takes `t_word`. Both selects may pick the same operand.
- R5: When `mask_mode` is 2'b01 (left mask) with zero fill, the `lmask_w` most significant true result bits are 0. All other bits follow R2.
- R6: When `mask_mode` is 2'b10 (right mask) with zero fill, the `rmask_w` least significant true result bits are 0. All other bits follow R2.
- R7: When `mask_mode` is 2'b11, the mask is the union of the left and right masks. The two masks may overlap.
- R8: When `md_fill` is 1, every masked true result bit is taken from the same bit of `md_word`, and unmasked bits follow R2.
- R9: A mask width of 0 gives an empty mask. A width of 16 or more covers the whole word.
- R10: A result appears on `res_n` at the first rising clock edge after its inputs are applied, and not earlier.
- R11: With one operand in both halves, a cycle of (16-n) mod 16 and an n-bit left mask with zero fill, the true result equals that operand logically shifted right by n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rf_word | input | 16 | Register-file operand |
| t_word | input | 16 | T register operand |
| md_word | input | 16 | Memory-data word used as fill |
| hi_src | input | 1 | Source of the high half: 0 register word, 1 T |
| lo_src | input | 1 | Source of the low half: 0 register word, 1 T |
| cyc_cnt | input | 4 | Left cycle count, 0 to 15 |
| lmask_w | input | 5 | Left mask width |
| rmask_w | input | 5 | Right mask width |
| mask_mode | input | 2 | Active masks: 00 none, 01 left, 10 right, 11 both |
| md_fill | input | 1 | 1 fills masked bits from md_word, 0 fills them with zero |
| res_n | output | 16 | Registered result, complemented |

## Verification
Three functions can act in the same cycle: the left mask, the right mask and the memory-data fill. When both masks are active, they can claim the same bit positions. The bench provokes this with directed vectors whose two widths add up to more than 16, with fill both on and off. It also draws random widths up to 20 under every mode. Each result is judged against a bench model that walks the bits one at a time. Under that model, a bit claimed by both masks must be filled exactly once, and never picks up a shifted bit.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    typedef enum logic [1:0] {
        MSK_NONE  = 2'b00,
        MSK_LEFT  = 2'b01,
        MSK_RIGHT = 2'b10,
        MSK_BOTH  = 2'b11
    } mask_mode_e;
endpackage

// File: rtl/mcs_cycler.sv
module mcs_cycler #(
    parameter int W  = 16,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  hi_word,
    input  logic [W-1:0]  lo_word,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  cycled
);
    logic [2*W-1:0] joined;
    logic [2*W-1:0] moved;

    assign joined = {hi_word, lo_word};
    // count < W, so the top half of a plain shift equals the top half of a rotate
    assign moved  = joined << cnt;
    assign cycled = moved[2*W-1:W];
endmodule

// File: rtl/mcs_mask_gen.sv
module mcs_mask_gen #(
    parameter int W  = 16,
    localparam int MW = $clog2(W) + 1
) (
    input  logic [MW-1:0] left_w,
    input  logic [MW-1:0] right_w,
    output logic [W-1:0]  left_m,
    output logic [W-1:0]  right_m
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // vector bit W-1 is the most significant (leftmost) position
        assign left_m[i]  = MW'(W - 1 - i) < left_w;
        assign right_m[i] = MW'(i) < right_w;
    end
endmodule

// File: rtl/mask_cycle_shifter.sv
module mask_cycle_shifter #(
    parameter int W  = 16,
    localparam int CW = $clog2(W),
    localparam int MW = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  rf_word,
    input  logic [W-1:0]  t_word,
    input  logic [W-1:0]  md_word,
    input  logic          hi_src,
    input  logic          lo_src,
    input  logic [CW-1:0] cyc_cnt,
    input  logic [MW-1:0] lmask_w,
    input  logic [MW-1:0] rmask_w,
    input  logic [1:0]    mask_mode,
    input  logic          md_fill,
    output logic [W-1:0]  res_n
);
    import mcs_pkg::*;

    typedef struct packed {
        logic [W-1:0] res_n;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0] hi_word, lo_word, cycled;
    logic [W-1:0] left_m, right_m;
    mask_mode_e   mode;

    assign hi_word = hi_src ? t_word : rf_word;
    assign lo_word = lo_src ? t_word : rf_word;
    assign mode    = mask_mode_e'(mask_mode);

    mcs_cycler #(.W(W)) u_cyc (
        .hi_word (hi_word),
        .lo_word (lo_word),
        .cnt     (cyc_cnt),
        .cycled  (cycled)
    );

    mcs_mask_gen #(.W(W)) u_msk (
        .left_w  (lmask_w),
        .right_w (rmask_w),
        .left_m  (left_m),
        .right_m (right_m)
    );

    always_comb begin
        logic [W-1:0] sel_m;
        logic [W-1:0] fill;
        unique case (mode)
            MSK_NONE:  sel_m = '0;
            MSK_LEFT:  sel_m = left_m;
            MSK_RIGHT: sel_m = right_m;
            default:   sel_m = left_m | right_m;
        endcase
        fill          = md_fill ? md_word : '0;
        state_d.res_n = ~((cycled & ~sel_m) | (fill & sel_m));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{res_n: '1};
        else        state_q <= state_d;
    end

    assign res_n = state_q.res_n;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
    parameter int W  = 16,
    localparam int CW = $clog2(W),
    localparam int MW = CW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  rf_word,
    input logic [W-1:0]  t_word,
    input logic [W-1:0]  md_word,
    input logic          hi_src,
    input logic          lo_src,
    input logic [CW-1:0] cyc_cnt,
    input logic [MW-1:0] lmask_w,
    input logic [MW-1:0] rmask_w,
    input logic [1:0]    mask_mode,
    input logic          md_fill,
    input logic [W-1:0]  res_n
);
    // R1
    reset_ones_chk: assert property (@(posedge clk)
        !rst_n |=> res_n == '1);

    // R3
    zero_count_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt == '0 && mask_mode == 2'b00)
        |=> res_n == ~($past(hi_src) ? $past(t_word) : $past(rf_word)));

    // R5
    left_zero_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_mode == 2'b01 && !md_fill && lmask_w != '0) |=> res_n[W-1]);

    // R6
    right_zero_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_mode == 2'b10 && !md_fill && rmask_w != '0) |=> res_n[0]);

    // R8
    full_md_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_mode == 2'b11 && md_fill && lmask_w >= MW'(W))
        |=> res_n == ~$past(md_word));
endmodule

bind mask_cycle_shifter mcs_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rf_word   (rf_word),
    .t_word    (t_word),
    .md_word   (md_word),
    .hi_src    (hi_src),
    .lo_src    (lo_src),
    .cyc_cnt   (cyc_cnt),
    .lmask_w   (lmask_w),
    .rmask_w   (rmask_w),
    .mask_mode (mask_mode),
    .md_fill   (md_fill),
    .res_n     (res_n)
);

// File: tb/sim_mask_cycle_shifter.sv
module sim_mask_cycle_shifter;
    localparam int  W = 16;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rf_word = '0, t_word = '0, md_word = '0;
    logic        hi_src = 1'b0, lo_src = 1'b0, md_fill = 1'b0;
    logic [3:0]  cyc_cnt = '0;
    logic [4:0]  lmask_w = '0, rmask_w = '0;
    logic [1:0]  mask_mode = '0;
    logic [15:0] res_n;
    int          n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mask_cycle_shifter u0 (
        .clk(clk), .rst_n(rst_n), .rf_word(rf_word), .t_word(t_word),
        .md_word(md_word), .hi_src(hi_src), .lo_src(lo_src), .cyc_cnt(cyc_cnt),
        .lmask_w(lmask_w), .rmask_w(rmask_w), .mask_mode(mask_mode),
        .md_fill(md_fill), .res_n(res_n)
    );

    // Bit-serial model, positions counted from the most significant bit (index 0).
    function automatic logic [15:0] model();
        logic [31:0] cat;
        logic [15:0] t;
        int lw, rw;
        cat = {hi_src ? t_word : rf_word, lo_src ? t_word : rf_word};
        lw = (lmask_w > 16) ? 16 : int'(lmask_w);
        rw = (rmask_w > 16) ? 16 : int'(rmask_w);
        for (int p = 0; p < 16; p++) begin
            logic b, in_l, in_r;
            b    = cat[31 - (p + int'(cyc_cnt))];
            in_l = mask_mode[0] && (p < lw);
            in_r = mask_mode[1] && (p >= 16 - rw);
            if (in_l || in_r) b = md_fill ? md_word[15 - p] : 1'b0;
            t[15 - p] = b;
        end
        return ~t;
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_run++;
        if (res_n !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, res_n, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [15:0] r, input logic [15:0] t,
                         input logic [15:0] m, input logic hs, input logic ls,
                         input logic [3:0] c, input logic [4:0] lw, input logic [4:0] rw,
                         input logic [1:0] mode, input logic fill);
        logic [15:0] exp;
        @(negedge clk);
        rf_word = r; t_word = t; md_word = m; hi_src = hs; lo_src = ls;
        cyc_cnt = c; lmask_w = lw; rmask_w = rw; mask_mode = mode; md_fill = fill;
        exp = model();
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        logic [31:0] seed_unused;
        logic [15:0] prev;
        seed_unused = $urandom(32'd4711);
        repeat (2) @(negedge clk);
        check("R1 reset", 16'hFFFF);
        rst_n = 1'b1;

        // R3: count 0 passes the high half
        apply("R3 count0", 16'h1234, 16'hABCD, 16'h0, 1'b1, 1'b0, 4'd0, 5'd0, 5'd0, 2'b00, 1'b0);
        check("R3 literal", ~16'hABCD);
        // R4: same operand both halves, and swapped halves
        apply("R4 t_t", 16'h1234, 16'h8001, 16'h0, 1'b1, 1'b1, 4'd1, 5'd0, 5'd0, 2'b00, 1'b0);
        check("R4 literal", ~16'h0003);
        apply("R4 r_t", 16'hF000, 16'h000F, 16'h0, 1'b0, 1'b1, 4'd4, 5'd0, 5'd0, 2'b00, 1'b0);
        check("R2 literal", ~16'h0000);
        // R11: right shift 0xF00F by 4 -> 0x0F00
        apply("R11 rsh", 16'hF00F, 16'h0, 16'h0, 1'b0, 1'b0, 4'd12, 5'd4, 5'd0, 2'b01, 1'b0);
        check("R11 literal", ~16'h0F00);
        // R9: width 0 is empty, width 16 and above is full
        apply("R9 empty", 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b0, 4'd0, 5'd0, 5'd0, 2'b11, 1'b0);
        check("R9 empty literal", 16'h0000);
        apply("R9 full", 16'hFFFF, 16'h0, 16'h5A5A, 1'b0, 1'b0, 4'd3, 5'd20, 5'd0, 2'b01, 1'b1);
        check("R9 full literal", ~16'h5A5A);
        // R7 + R8: overlapping masks, zero and memory-data fill
        apply("R7 overlap", 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b0, 4'd0, 5'd10, 5'd9, 2'b11, 1'b0);
        check("R7 literal", 16'hFFFF);
        apply("R8 overlap", 16'hFFFF, 16'h0, 16'h1248, 1'b0, 1'b0, 4'd0, 5'd10, 5'd9, 2'b11, 1'b1);
        check("R8 literal", ~16'h1248);
        apply("R6 right", 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b0, 4'd0, 5'd0, 5'd3, 2'b10, 1'b0);
        check("R6 literal", ~16'hFFF8);
        apply("R5 left", 16'hFFFF, 16'h0, 16'h0, 1'b0, 1'b0, 4'd0, 5'd3, 5'd0, 2'b01, 1'b0);
        check("R5 literal", ~16'h1FFF);

        // R10: nothing moves before the edge
        prev = res_n;
        @(negedge clk);
        rf_word = 16'h0F0F; t_word = 16'h3C3C; mask_mode = 2'b00; cyc_cnt = 4'd0;
        hi_src = 1'b0; md_fill = 1'b0;
        #1;
        check("R10 hold", prev);
        @(negedge clk);
        check("R10 update", ~16'h0F0F);

        for (int k = 0; k < 400; k++) begin
            logic [1:0] mode;
            logic fill;
            string tag;
            mode = 2'($urandom);
            fill = 1'($urandom);
            if (fill && mode != 2'b00) tag = "R8 random";
            else case (mode)
                2'b00: tag = "R2 random";
                2'b01: tag = "R5 random";
                2'b10: tag = "R6 random";
                default: tag = "R7 random";
            endcase
            apply(tag, 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
                  1'($urandom), 4'($urandom), 5'($urandom_range(20)), 5'($urandom_range(20)),
                  mode, fill);
        end

        // R1 again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", 16'hFFFF);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule